// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

A memory-mapped watchdog with a down-counter that is loaded from a load register. When the counter reaches zero for the first time, it raises an interrupt and reloads itself from the load value. If the interrupt is still pending at the next zero, it asserts a sticky system-reset output, but only when reset generation is enabled. Software keeps the system alive in one of two ways: it clears the interrupt, or it rewrites the load value. Either action restarts the countdown.

All writes to the load, control and interrupt-clear registers are ignored while the block is locked. The block comes out of reset locked. Writing a 32-bit key to the lock register opens it, and writing any other value to the same register closes it again.

Register access uses a single-cycle, APB-style port: an access happens on a cycle where both `psel` and `penable` are high. Read data is registered and appears on the cycle after the access.

Top module: `wdog_twostage`

Register offsets:
- 0x000: load value, read/write.
- 0x004: current count, read-only.
- 0x008: control. Bit 0 runs the counter and unmasks the interrupt. Bit 1 arms reset generation.
- 0x00C: interrupt clear, write-only.
- 0x010: raw interrupt status in bit 0.
- 0x014: masked interrupt status in bit 0.
- 0xC00: lock.

## Requirements
- R1: After the synchronous reset, the load and count registers read as all ones (CNT_W bits wide), control reads 0, `irq_o` and `wdog_rst_o` are 0, and the lock register reads 1.
- R2: Writing 0x1ACCE551 to offset 0xC00 unlocks the block, and the lock register then reads 0. Writing any other value to 0xC00 locks the block, and it then reads 1. While the block is locked, writes to 0x000, 0x008 and 0x00C have no effect.
- R3: While control bit 0 is set, the count decreases by one on every cycle. When the count is zero and no interrupt is pending, the raw status bit 0 is set and the count reloads from the load register.
- R4: When the count is zero with the interrupt pending and control bits 0 and 1 both set, `wdog_rst_o` rises. It then stays high until the synchronous reset is applied, whatever is written afterwards.
- R5: When the count is zero with the interrupt pending and control bit 1 clear, no reset is produced. The count reloads and the interrupt stays pending.
- R6: Writing any value to offset 0x00C clears the pending interrupt and reloads the count from the load register.
- R7: Writing offset 0x000 sets the load register and loads the count with the new value on the same edge. The value is truncated to CNT_W bits.
- R8: Masked status bit 0, and `irq_o`, equal the raw status ANDed with control bit 0. When control bit 0 is clear, the count holds its value.
- R9: Read data appears on `prdata` in the cycle after the read access. Offsets that are not mapped, and the interrupt-clear offset, read as 0.
- R10: With a load value of 0 and both control bits set, the interrupt sets on the first enabled cycle and `wdog_rst_o` rises on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Register select |
| penable | input | 1 | Access strobe, qualified by psel |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Registered read data |
| irq_o | output | 1 | Masked interrupt |
| wdog_rst_o | output | 1 | Sticky system reset request |

## Verification
The bench builds the block with CNT_W set to 16, so the all-ones value after reset is 0xFFFF and truncation of load writes can be checked. Loads stay small, between 0 and 5, so that both expiries, the gap between them and the load-of-zero fast path each complete in a few cycles. A behavioural model follows the count, the pending interrupt, the lock and the reset request on every cycle. It is compared with `irq_o`, `wdog_rst_o` and each read result. It also covers the same-edge priorities, where a write meets an expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [11:0] OFF_LOAD  = 12'h000;
  localparam logic [11:0] OFF_COUNT = 12'h004;
  localparam logic [11:0] OFF_CTRL  = 12'h008;
  localparam logic [11:0] OFF_CLR   = 12'h00C;
  localparam logic [11:0] OFF_RAW   = 12'h010;
  localparam logic [11:0] OFF_MASK  = 12'h014;
  localparam logic [11:0] OFF_LOCK  = 12'hC00;
  localparam logic [31:0] UNLOCK_KEY = 32'h1ACCE551;

  typedef struct packed {
    logic rst_arm;  // bit 1
    logic run;      // bit 0
  } ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              ris_q,
  output logic              wr_load,
  output logic              wr_clr,
  output logic [CNT_W-1:0]  load_q,
  output ctrl_t             ctrl_q,
  output ctrl_t             ctrl_d,
  output logic              locked_q,
  output logic [31:0]       prdata
);
  logic access, wr, rd;
  logic hit_load, hit_ctrl, hit_clr, hit_lock;
  logic [31:0] rd_mux;

  assign access   = psel && penable;
  assign wr       = access && pwrite;
  assign rd       = access && !pwrite;
  assign hit_load = (paddr == ADDR_W'(OFF_LOAD));
  assign hit_ctrl = (paddr == ADDR_W'(OFF_CTRL));
  assign hit_clr  = (paddr == ADDR_W'(OFF_CLR));
  assign hit_lock = (paddr == ADDR_W'(OFF_LOCK));

  assign wr_load = wr && hit_load && !locked_q;
  assign wr_clr  = wr && hit_clr  && !locked_q;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr && hit_ctrl && !locked_q) ctrl_d = ctrl_t'(pwdata[1:0]);
  end

  always_comb begin
    rd_mux = '0;
    unique case (paddr)
      ADDR_W'(OFF_LOAD):  rd_mux = 32'(load_q);
      ADDR_W'(OFF_COUNT): rd_mux = 32'(cnt_q);
      ADDR_W'(OFF_CTRL):  rd_mux = 32'(ctrl_q);
      ADDR_W'(OFF_RAW):   rd_mux = 32'(ris_q);
      ADDR_W'(OFF_MASK):  rd_mux = 32'(ris_q && ctrl_q.run);
      ADDR_W'(OFF_LOCK):  rd_mux = 32'(locked_q);
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q   <= '1;
      ctrl_q   <= '0;
      locked_q <= 1'b1;
      prdata   <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (wr_load) load_q <= pwdata[CNT_W-1:0];
      if (wr && hit_lock) locked_q <= (pwdata != UNLOCK_KEY);
      if (rd) prdata <= rd_mux;
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            ctrl_q,
  input  ctrl_t            ctrl_d,
  input  logic             wr_load,
  input  logic             wr_clr,
  input  logic [CNT_W-1:0] new_load,
  input  logic [CNT_W-1:0] load_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ris_q,
  output logic             irq_q,
  output logic             wrst_q
);
  logic [CNT_W-1:0] cnt_d;
  logic ris_d, wrst_d, at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    ris_d  = ris_q;
    wrst_d = wrst_q;
    if (wr_load) begin
      cnt_d = new_load;
    end else if (wr_clr) begin
      ris_d = 1'b0;
      cnt_d = load_q;
    end else if (ctrl_q.run) begin
      if (at_zero) begin
        cnt_d = load_q;
        if (!ris_q) ris_d = 1'b1;
        else if (ctrl_q.rst_arm) wrst_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '1;
      ris_q  <= 1'b0;
      irq_q  <= 1'b0;
      wrst_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      ris_q  <= ris_d;
      irq_q  <= ris_d && ctrl_d.run;
      wrst_q <= wrst_d;
    end
  end
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              irq_o,
  output logic              wdog_rst_o
);
  logic             wr_load, wr_clr, locked_q, ris_q;
  logic [CNT_W-1:0] load_q, cnt_q;
  ctrl_t            ctrl_q, ctrl_d;

  wdog_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .cnt_q(cnt_q), .ris_q(ris_q),
    .wr_load(wr_load), .wr_clr(wr_clr), .load_q(load_q), .ctrl_q(ctrl_q),
    .ctrl_d(ctrl_d), .locked_q(locked_q), .prdata(prdata)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .ctrl_q(ctrl_q), .ctrl_d(ctrl_d),
    .wr_load(wr_load), .wr_clr(wr_clr), .new_load(pwdata[CNT_W-1:0]),
    .load_q(load_q), .cnt_q(cnt_q), .ris_q(ris_q), .irq_q(irq_o),
    .wrst_q(wdog_rst_o)
  );
endmodule

// File: rtl/wdog_twostage_chk.sv
module wdog_twostage_chk #(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic              irq_o,
  input logic              wdog_rst_o,
  input logic              locked_q,
  input logic              wr_load,
  input logic              wr_clr,
  input logic              ris_q,
  input logic [1:0]        ctrl_bits,
  input logic [CNT_W-1:0]  load_q,
  input logic [CNT_W-1:0]  cnt_q
);
  a_r4_rst_sticky: assert property (@(posedge clk) disable iff (rst)
    wdog_rst_o |=> wdog_rst_o);

  a_r8_irq_masked: assert property (@(posedge clk) disable iff (rst)
    irq_o == (ris_q && ctrl_bits[0]));

  a_r3_first_expiry: assert property (@(posedge clk) disable iff (rst)
    (ctrl_bits[0] && cnt_q == '0 && !ris_q && !wr_load && !wr_clr)
      |=> (ris_q && cnt_q == $past(load_q)));

  a_r8_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_bits[0] && !wr_load && !wr_clr) |=> $stable(cnt_q));

  a_r2_locked_load: assert property (@(posedge clk) disable iff (rst)
    (locked_q && psel && penable && pwrite && paddr == '0) |=> $stable(load_q));

  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    wr_clr |=> !ris_q);
endmodule

bind wdog_twostage wdog_twostage_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .irq_o(irq_o), .wdog_rst_o(wdog_rst_o), .locked_q(locked_q),
  .wr_load(wr_load), .wr_clr(wr_clr), .ris_q(ris_q), .ctrl_bits(ctrl_q),
  .load_q(load_q), .cnt_q(cnt_q)
);

// File: tb/wdog_twostage_bench.sv
module wdog_twostage_bench;
  localparam int PERIOD = 10;
  localparam int CW     = 16;
  localparam int AW     = 12;

  logic clk = 1'b0, rst = 1'b1;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [AW-1:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic irq_o, wdog_rst_o;
  int n_tests = 0, n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  wdog_twostage #(.ADDR_W(AW), .CNT_W(CW)) u_wdog_twostage (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq_o(irq_o),
    .wdog_rst_o(wdog_rst_o)
  );

  // Behavioural reference model
  int unsigned m_load, m_cnt, m_ctrl, m_rdata;
  bit m_ris, m_rst, m_lock, m_rdv;

  function automatic int unsigned model_read(int unsigned a);
    case (a)
      'h000: return m_load;
      'h004: return m_cnt;
      'h008: return m_ctrl;
      'h010: return m_ris;
      'h014: return (m_ris && m_ctrl[0]) ? 1 : 0;
      'hC00: return m_lock;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_load = 'hFFFF; m_cnt = 'hFFFF; m_ctrl = 0; m_ris = 0; m_rst = 0;
      m_lock = 1; m_rdata = 0; m_rdv = 0;
    end else begin
      bit acc, dl, dc, dk;
      int unsigned nctrl;
      acc = psel && penable;
      m_rdv = acc && !pwrite;
      if (m_rdv) m_rdata = model_read(paddr);
      dl = acc && pwrite && paddr == 'h000 && !m_lock;
      dc = acc && pwrite && paddr == 'h00C && !m_lock;
      nctrl = (acc && pwrite && paddr == 'h008 && !m_lock) ? (pwdata & 3) : m_ctrl;
      dk = acc && pwrite && paddr == 'hC00;
      if (dl) begin
        m_load = pwdata & 'hFFFF; m_cnt = m_load;
      end else if (dc) begin
        m_ris = 0; m_cnt = m_load;
      end else if (m_ctrl[0]) begin
        if (m_cnt == 0) begin
          if (!m_ris) m_ris = 1;
          else if (m_ctrl[1]) m_rst = 1;
          m_cnt = m_load;
        end else m_cnt = m_cnt - 1;
      end
      m_ctrl = nctrl;
      if (dk) m_lock = (pwdata != 32'h1ACCE551);
    end
  end

  task automatic check(string req, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check("R8 irq_o vs model", irq_o, (m_ris && m_ctrl[0]) ? 1 : 0);
      check("R4 wdog_rst_o vs model", wdog_rst_o, m_rst);
      if (m_rdv) check("R9 prdata vs model", prdata, m_rdata);
    end
  end

  task automatic wr(input int unsigned a, input int unsigned d);
    psel = 1; penable = 1; pwrite = 1; paddr = AW'(a); pwdata = d;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input int unsigned a, output int unsigned d);
    psel = 1; penable = 1; pwrite = 0; paddr = AW'(a);
    @(negedge clk);
    psel = 0; penable = 0;
    d = prdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1; idle(2); rst = 0;
  endtask

  initial begin
    int unsigned v, v2;
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1 irq_o", irq_o, 0);
    check("R1 wdog_rst_o", wdog_rst_o, 0);
    rd('hC00, v); check("R1 lock", v, 1);
    rd('h000, v); check("R1 load", v, 'hFFFF);
    rd('h004, v); check("R1 count", v, 'hFFFF);
    rd('h008, v); check("R1 ctrl", v, 0);
    // R2 locked writes ignored
    wr('h000, 7); rd('h000, v); check("R2 locked load", v, 'hFFFF);
    wr('h008, 1); rd('h008, v); check("R2 locked ctrl", v, 0);
    wr('hC00, 32'h1ACCE551); rd('hC00, v); check("R2 unlocked", v, 0);
    // R7 load write reloads, truncated
    wr('h000, 32'h0003_0005); rd('h004, v); check("R7 count after load", v, 5);
    rd('h000, v); check("R7 load truncated", v, 5);
    // R3 counting and first expiry
    wr('h008, 1); idle(8);
    rd('h010, v); check("R3 raw set", v, 1);
    rd('h014, v); check("R8 masked set", v, 1);
    // R6 clear
    wr('h00C, 'hDEAD); rd('h010, v); check("R6 raw cleared", v, 0);
    // R8 stop holds
    wr('h008, 0); rd('h004, v); idle(3); rd('h004, v2);
    check("R8 count held", v2, v);
    // R9 unmapped
    rd('h00C, v); check("R9 clr reads 0", v, 0);
    rd('h100, v); check("R9 unmapped 0", v, 0);
    // R5 second expiry without reset arm
    wr('h000, 3); wr('h008, 1); idle(20);
    check("R5 no reset", wdog_rst_o, 0);
    rd('h010, v); check("R5 irq pending", v, 1);
    // R4 reset arm, sticky
    wr('h008, 3); idle(10);
    check("R4 reset asserted", wdog_rst_o, 1);
    wr('h008, 0); wr('h00C, 0); idle(2);
    check("R4 reset sticky", wdog_rst_o, 1);
    // R2 relock blocks ctrl write
    wr('hC00, 1); rd('hC00, v); check("R2 relocked", v, 1);
    wr('h008, 3); rd('h008, v); check("R2 ctrl ignored", v, 0);
    // R10 load zero fast path
    do_reset();
    check("R1 reset clears wdog_rst_o", wdog_rst_o, 0);
    wr('hC00, 32'h1ACCE551); wr('h000, 0); wr('h008, 3);
    check("R10 not yet", wdog_rst_o, 0);
    idle(1); check("R10 irq first", irq_o, 1);
    check("R10 reset not first", wdog_rst_o, 0);
    idle(1); check("R10 reset second", wdog_rst_o, 1);
    // Load write during a run
    do_reset();
    wr('hC00, 32'h1ACCE551); wr('h000, 2); wr('h008, 1); idle(2);
    wr('h000, 4); idle(12);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule